// File: doc/BRIEF.md
# I2C Byte-Completion Interrupt Flag and Clock-Stretch Control

This block owns the per-byte interrupt flag of an I2C bus interface. When the bit counter reports that a byte and its acknowledge bit have gone by, the block decides from the current bus role whether software must service the transfer. If so, it raises the flag, and it keeps the clock line pulled low until software releases it.

Software sees the flag through a readback output. It clears the flag, and so releases the clock, by writing 0. A separate interrupt-enable bit gates the request line. Start and stop conditions seen on the bus discard a pending flag.

The block also covers one corner case. A master request made while the bus looks idle but a line is already low leads to a lost arbitration. In that case no interrupt may be raised.

Top module: `i2c_bytedone_irq`

## Requirements
- R1: On a `byte_done` strobe the flag sets if at least one of `is_master`, `addr_match`, `gen_call`, `arb_lost` or `foreign_start` is 1. With none of them 1 it stays 0. Without a `byte_done` strobe the flag never rises.
- R2: `scl_hold` is 1 in the same cycle as a `byte_done` strobe that sets the flag. It is also 1 in every cycle where `flag_rd` is 1, `if_en` is 1, and neither `start_det` nor `stop_det` is asserted.
- R3: A strobe on `wr_flag` with `wr_flag_val` = 0 clears the flag at the next edge. `scl_hold` then drops to 0.
- R4: A strobe on `wr_flag` with `wr_flag_val` = 1 leaves the flag, `scl_hold` and `irq` unchanged.
- R5: `start_det` or `stop_det` forces the flag to 0 at the next edge, even if `byte_done` is asserted in the same cycle. `scl_hold` is 0 in that cycle.
- R6: `mst_req` with `bus_busy` = 0 and `sda_in` or `scl_in` at 0 blocks the flag from setting. This holds in that cycle and afterwards, until a later start or stop, a clean `mst_req`, or disable.
- R7: After reset, and whenever `if_en` = 0, the flag is 0. `scl_hold` is 0 and no byte can set the flag. Reset also clears the interrupt enable and the start guard.
- R8: `irq` is 1 exactly when the flag is 1 and the interrupt enable (written by a `wr_ie` strobe with value `wr_ie_val`) is 1.
- R9: A setting `byte_done` beats a clearing flag write in the same cycle. The flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_en | input | 1 | Interface enable |
| byte_done | input | 1 | Strobe: byte plus ACK completed |
| start_det | input | 1 | Strobe: start condition seen |
| stop_det | input | 1 | Strobe: stop condition seen |
| bus_busy | input | 1 | Bus is busy |
| is_master | input | 1 | Device is bus master |
| addr_match | input | 1 | Addressed as slave |
| gen_call | input | 1 | General call address received |
| arb_lost | input | 1 | Arbitration lost |
| foreign_start | input | 1 | Another agent tried a start while busy |
| mst_req | input | 1 | Strobe: software requests master mode |
| sda_in | input | 1 | Sampled SDA level |
| scl_in | input | 1 | Sampled SCL level |
| wr_flag | input | 1 | Strobe: software writes the flag |
| wr_flag_val | input | 1 | Value written to the flag |
| wr_ie | input | 1 | Strobe: software writes interrupt enable |
| wr_ie_val | input | 1 | Value written to interrupt enable |
| irq | output | 1 | Interrupt request |
| flag_rd | output | 1 | Flag readback |
| scl_hold | output | 1 | Pull SCL low |

## Verification
The hardest case to reach is the blocked interrupt after a master request on an idle bus with a low line. The stimulus gets there by holding `bus_busy` at 0 and driving `sda_in` or `scl_in` low while pulsing `mst_req`. It then presents `arb_lost` with `byte_done`, both in the same cycle as the request and one cycle later. After that, a start condition clears the guard, and the same byte event is repeated to show that the flag now sets.

// File: rtl/bdi_pkg.sv
package bdi_pkg;

    typedef struct packed {
        logic master;
        logic addressed;
        logic gcall;
        logic arb_lost;
        logic foreign_start;
    } bdi_role_t;

    localparam int ROLE_W = $bits(bdi_role_t);

    typedef enum logic [2:0] {
        ACT_KEEP,
        ACT_SET,
        ACT_SW_CLR,
        ACT_BUS_CLR,
        ACT_OFF_CLR
    } bdi_act_e;

    // Priority: disable, bus condition, byte set, software clear
    function automatic bdi_act_e pick_action(
        input logic en,
        input logic bus_evt,
        input logic set_req,
        input logic sw_clr
    );
        if (!en)     return ACT_OFF_CLR;
        if (bus_evt) return ACT_BUS_CLR;
        if (set_req) return ACT_SET;
        if (sw_clr)  return ACT_SW_CLR;
        return ACT_KEEP;
    endfunction

endpackage

// File: rtl/bdi_cause_eval.sv
module bdi_cause_eval
    import bdi_pkg::*;
#(
    parameter logic [ROLE_W-1:0] ROLE_MASK = '1
) (
    input  bdi_role_t role,
    output logic      any_role
);
    logic [ROLE_W-1:0] hits;

    for (genvar g = 0; g < ROLE_W; g++) begin : g_hit
        assign hits[g] = role[g] & ROLE_MASK[g];
    end

    assign any_role = |hits;
endmodule

// File: rtl/bdi_start_guard.sv
module bdi_start_guard #(
    parameter bit START_GUARD = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic mst_req,
    input  logic bus_busy,
    input  logic sda_in,
    input  logic scl_in,
    input  logic start_det,
    input  logic stop_det,
    output logic suppress
);
    if (START_GUARD) begin : g_guard
        logic trip;
        logic sup_q;

        assign trip = mst_req & ~bus_busy & (~sda_in | ~scl_in);

        always_ff @(posedge clk) begin
            if (rst || !en || start_det || stop_det) begin
                sup_q <= 1'b0;
            end else if (trip) begin
                sup_q <= 1'b1;
            end else if (mst_req) begin
                sup_q <= 1'b0;
            end
        end

        assign suppress = trip | sup_q;

        AST_GUARD_LATCHES: assert property (@(posedge clk) disable iff (rst)
            (trip && en && !start_det && !stop_det) |=> suppress); // R6
    end else begin : g_noguard
        assign suppress = 1'b0;
    end
endmodule

// File: rtl/bdi_flag_reg.sv
module bdi_flag_reg
    import bdi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic bus_evt,
    input  logic set_req,
    input  logic sw_clr,
    input  logic ie_wr,
    input  logic ie_val,
    output logic flag_q,
    output logic ie_q
);
    bdi_act_e act;

    assign act = pick_action(en, bus_evt, set_req, sw_clr);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            unique case (act)
                ACT_SET:     flag_q <= 1'b1;
                ACT_KEEP:    flag_q <= flag_q;
                default:     flag_q <= 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q <= 1'b0;
        end else if (ie_wr) begin
            ie_q <= ie_val;
        end
    end

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (en && !bus_evt && set_req && sw_clr) |=> flag_q); // R9
    AST_BUS_CLEARS: assert property (@(posedge clk) disable iff (rst)
        bus_evt |=> !flag_q); // R5
endmodule

// File: rtl/i2c_bytedone_irq.sv
module i2c_bytedone_irq
    import bdi_pkg::*;
#(
    parameter bit                START_GUARD = 1'b1,
    parameter logic [ROLE_W-1:0] ROLE_MASK   = '1
) (
    input  logic clk,
    input  logic rst,
    input  logic if_en,
    input  logic byte_done,
    input  logic start_det,
    input  logic stop_det,
    input  logic bus_busy,
    input  logic is_master,
    input  logic addr_match,
    input  logic gen_call,
    input  logic arb_lost,
    input  logic foreign_start,
    input  logic mst_req,
    input  logic sda_in,
    input  logic scl_in,
    input  logic wr_flag,
    input  logic wr_flag_val,
    input  logic wr_ie,
    input  logic wr_ie_val,
    output logic irq,
    output logic flag_rd,
    output logic scl_hold
);
    bdi_role_t role;
    logic      any_role;
    logic      suppress;
    logic      bus_evt;
    logic      set_req;
    logic      sw_clr;
    logic      flag_q;
    logic      ie_q;

    assign role = '{master:        is_master,
                    addressed:     addr_match,
                    gcall:         gen_call,
                    arb_lost:      arb_lost,
                    foreign_start: foreign_start};

    bdi_cause_eval #(.ROLE_MASK(ROLE_MASK)) i_cause (
        .role     (role),
        .any_role (any_role)
    );

    bdi_start_guard #(.START_GUARD(START_GUARD)) i_guard (
        .clk       (clk),
        .rst       (rst),
        .en        (if_en),
        .mst_req   (mst_req),
        .bus_busy  (bus_busy),
        .sda_in    (sda_in),
        .scl_in    (scl_in),
        .start_det (start_det),
        .stop_det  (stop_det),
        .suppress  (suppress)
    );

    assign bus_evt = start_det | stop_det;
    assign set_req = byte_done & any_role & ~suppress;
    assign sw_clr  = wr_flag & ~wr_flag_val;

    bdi_flag_reg i_flag (
        .clk     (clk),
        .rst     (rst),
        .en      (if_en),
        .bus_evt (bus_evt),
        .set_req (set_req),
        .sw_clr  (sw_clr),
        .ie_wr   (wr_ie),
        .ie_val  (wr_ie_val),
        .flag_q  (flag_q),
        .ie_q    (ie_q)
    );

    // Hold is raised combinationally with the setting byte so no clock escapes
    assign scl_hold = if_en & ~bus_evt & (flag_q | set_req);
    assign flag_rd  = flag_q;
    assign irq      = flag_q & ie_q;

    AST_NO_SET_WITHOUT_BYTE: assert property (@(posedge clk) disable iff (rst)
        (!flag_rd && !byte_done) |=> !flag_rd); // R1
    AST_HOLD_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        (flag_rd && if_en && !start_det && !stop_det) |-> scl_hold); // R2
    AST_HOLD_PRECEDES_FLAG: assert property (@(posedge clk) disable iff (rst)
        (scl_hold && !flag_rd) |=> flag_rd); // R2
    AST_SW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_flag && !wr_flag_val && !byte_done) |=> !flag_rd); // R3
    AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (flag_rd && wr_flag && wr_flag_val && if_en && !start_det && !stop_det)
        |=> flag_rd); // R4
    AST_GUARD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (mst_req && !bus_busy && (!sda_in || !scl_in) && !flag_rd)
        |=> !flag_rd); // R6
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !if_en |=> !flag_rd); // R7
    AST_OFF_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !if_en |-> !scl_hold); // R7
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag_rd); // R8
endmodule

// File: tb/test_i2c_bytedone_irq.sv
`timescale 1ns/100ps
module test_i2c_bytedone_irq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic if_en = 1'b1, byte_done = 1'b0, start_det = 1'b0, stop_det = 1'b0;
    logic bus_busy = 1'b1, is_master = 1'b0, addr_match = 1'b0, gen_call = 1'b0;
    logic arb_lost = 1'b0, foreign_start = 1'b0, mst_req = 1'b0;
    logic sda_in = 1'b1, scl_in = 1'b1;
    logic wr_flag = 1'b0, wr_flag_val = 1'b0, wr_ie = 1'b0, wr_ie_val = 1'b0;
    logic irq, flag_rd, scl_hold;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  flag;
        logic  irq;
        string req;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    i2c_bytedone_irq i_i2c_bytedone_irq (
        .clk(clk), .rst(rst), .if_en(if_en), .byte_done(byte_done),
        .start_det(start_det), .stop_det(stop_det), .bus_busy(bus_busy),
        .is_master(is_master), .addr_match(addr_match), .gen_call(gen_call),
        .arb_lost(arb_lost), .foreign_start(foreign_start), .mst_req(mst_req),
        .sda_in(sda_in), .scl_in(scl_in), .wr_flag(wr_flag),
        .wr_flag_val(wr_flag_val), .wr_ie(wr_ie), .wr_ie_val(wr_ie_val),
        .irq(irq), .flag_rd(flag_rd), .scl_hold(scl_hold)
    );

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", what, act, exp);
        end
    endtask

    // Monitor: compare post-edge state against queued expectations
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            check(flag_rd, it.flag, {it.req, " flag_rd"});
            check(irq, it.irq, {it.req, " irq"});
        end
    end

    // Driver: inputs already set after a falling edge
    task automatic go(input logic eh, input logic ef, input logic ei, input string r);
        exp_t it;
        #1;
        check(scl_hold, eh, {r, " scl_hold"});
        it.flag = ef; it.irq = ei; it.req = r;
        sb.push_back(it);
        @(negedge clk);
        byte_done = 0; start_det = 0; stop_det = 0; mst_req = 0;
        wr_flag = 0; wr_flag_val = 0; wr_ie = 0; wr_ie_val = 0;
    endtask

    task automatic no_roles();
        is_master = 0; addr_match = 0; gen_call = 0; arb_lost = 0; foreign_start = 0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(flag_rd, 1'b0, "R7 reset flag_rd");
        check(irq, 1'b0, "R7 reset irq");
        check(scl_hold, 1'b0, "R7 reset scl_hold");
        rst = 0;
        @(negedge clk);

        // R1 no role
        byte_done = 1; go(0, 0, 0, "R1 no role");
        // R1 R2 master
        is_master = 1; byte_done = 1; go(1, 1, 0, "R1 R2 master set");
        no_roles();
        go(1, 1, 0, "R2 hold while flag");
        wr_flag = 1; wr_flag_val = 1; go(1, 1, 0, "R4 write one");
        wr_ie = 1; wr_ie_val = 1; go(1, 1, 1, "R8 ie on");
        wr_flag = 1; wr_flag_val = 0; go(1, 0, 0, "R3 clear write");
        go(0, 0, 0, "R3 hold released");

        addr_match = 1; byte_done = 1; go(1, 1, 1, "R1 addressed");
        no_roles(); wr_flag = 1; go(1, 0, 0, "R3 clear");
        gen_call = 1; byte_done = 1; go(1, 1, 1, "R1 general call");
        no_roles(); wr_flag = 1; go(1, 0, 0, "R3 clear");
        arb_lost = 1; byte_done = 1; go(1, 1, 1, "R1 arb lost");
        no_roles(); wr_flag = 1; go(1, 0, 0, "R3 clear");
        foreign_start = 1; byte_done = 1; go(1, 1, 1, "R1 foreign start");
        no_roles();

        // R5 start clears; stop beats byte
        start_det = 1; go(0, 0, 0, "R5 start clears");
        is_master = 1; byte_done = 1; stop_det = 1; go(0, 0, 0, "R5 stop beats byte");
        // R9 set beats clear
        byte_done = 1; wr_flag = 1; go(1, 1, 1, "R9 set beats clear");
        no_roles(); wr_flag = 1; go(1, 0, 0, "R3 clear");
        wr_ie = 1; wr_ie_val = 0; go(0, 0, 0, "R8 ie off");
        is_master = 1; byte_done = 1; go(1, 1, 0, "R8 flag without ie");
        no_roles(); wr_flag = 1; wr_ie = 1; wr_ie_val = 1; go(1, 0, 0, "R3 clear");

        // R6 guard: idle bus, SDA low
        bus_busy = 0; sda_in = 0; mst_req = 1; go(0, 0, 0, "R6 request trips");
        arb_lost = 1; byte_done = 1; go(0, 0, 0, "R6 blocked later");
        no_roles(); sda_in = 1; start_det = 1; go(0, 0, 0, "R6 start rearms");
        arb_lost = 1; byte_done = 1; go(1, 1, 1, "R6 contrast sets");
        no_roles(); wr_flag = 1; go(1, 0, 0, "R3 clear");
        scl_in = 0; mst_req = 1; arb_lost = 1; byte_done = 1; go(0, 0, 0, "R6 blocked same cycle");
        no_roles(); scl_in = 1; stop_det = 1; bus_busy = 1; go(0, 0, 0, "R6 stop rearms");

        // R7 disable
        is_master = 1; byte_done = 1; go(1, 1, 1, "R7 setup");
        no_roles(); if_en = 0; go(0, 0, 0, "R7 disable clears");
        is_master = 1; byte_done = 1; go(0, 0, 0, "R7 disabled no set");
        no_roles(); if_en = 1; go(0, 0, 0, "R7 reenabled idle");

        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule